// File: doc/BRIEF.md
# Remote-Store Network Endpoint

This block joins a small in-order core to the mesh router of its node. The core presents 32-bit load and store requests. The upper ten address bits name a node and the lower 22 bits name a word address inside that node's memory, so one flat space covers every node with no cache and no translation. A request whose node field equals the node's own identifier goes to the local memory port, and both loads and stores are allowed there. A store whose node field names another node is packed into one 80-bit flit and handed to the data network in the same cycle. A load to another node is not supported: it raises an error pulse and is dropped.

A counter at the source meters the outstanding remote stores. It starts at a parameterised maximum and loses one credit for each flit the router accepts. It gains one for each credit packet that arrives on the separate narrow credit network and carries this node's address. When no credit is left, remote stores are held back from the core through the request handshake. The request path has no register stage, so one remote store per cycle can be injected while credits and router acceptance allow.

The request, memory and flit interfaces use valid/ready. A transfer happens on a rising edge where both valid and ready are high. The holder of valid keeps its payload stable until that edge. The request ready is driven by the chosen destination: the memory ready for local requests, or credits and router ready together for remote stores. Credit packets have no ready, and one credit is accepted in each cycle where the credit valid is high.

Top module: `rse_endpoint`

## Requirements
- R1: The node field is address bits 31:22 and the memory address is bits 21:0. A request whose node field equals `my_node_i` is local. A valid local request, load or store, drives `mem_valid_o` with its write flag, memory address, data and byte mask. In that case `req_ready_o` equals `mem_ready_i`, and no flit is produced.
- R2: A remote store drives `flit_o` as follows. Bits 79:70 hold the source node (`my_node_i`). Bits 69:68 hold the opcode 2'b01 for a store. Bits 67:64 hold the byte mask. Bits 63:32 hold the data, bits 31:22 the destination node and bits 21:0 the memory address.
- R3: `credit_cnt_o` is CREDIT_MAX after reset and never exceeds it. It falls by one on each cycle where a flit is accepted (`flit_valid_o` and `flit_ready_i` high) and no credit arrives.
- R4: While `credit_cnt_o` is zero, a remote store keeps `flit_valid_o` and `req_ready_o` low.
- R5: When a flit is accepted and a matching credit arrives in the same cycle, `credit_cnt_o` keeps its value.
- R6: A credit is counted only if `cred_node_i` equals the low CRED_W bits of `my_node_i`. Any other credit packet leaves the counter unchanged.
- R7: A valid remote load is accepted at once (`req_ready_o` high). It pulses `rload_err_o` for that cycle and produces neither a flit nor a memory request.
- R8: While `flit_ready_i` is low, a pending remote store holds `flit_valid_o` high with its flit while credits remain, keeps `req_ready_o` low, and consumes no credit.
- R9: With credits available and the router ready, a remote store is accepted on every consecutive cycle, one flit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| my_node_i | input | 10 | This node's identifier |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Core request accepted |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Global address |
| req_data_i | input | 32 | Store data |
| req_mask_i | input | 4 | Byte mask |
| mem_valid_o | output | 1 | Local memory request valid |
| mem_ready_i | input | 1 | Local memory ready |
| mem_write_o | output | 1 | Local write flag |
| mem_addr_o | output | 22 | Local word address |
| mem_data_o | output | 32 | Local store data |
| mem_mask_o | output | 4 | Local byte mask |
| flit_valid_o | output | 1 | Data-network flit valid |
| flit_ready_i | input | 1 | Router accepts flit |
| flit_o | output | 80 | Packed remote store |
| cred_valid_i | input | 1 | Credit packet valid |
| cred_node_i | input | 9 | Credit packet node address |
| credit_cnt_o | output | 4 | Available credits |
| rload_err_o | output | 1 | Remote load error pulse |

## Verification
The assertions assume that credits come back only for stores this node has injected, so no credit arrives while the counter is at its maximum, and that `my_node_i` stays constant outside reset. The bench's reference model tracks how many credits are owed. It raises a matching credit only while that count is positive, and any surplus credit packets it sends carry a node address that does not match. Stimulus mixes local, remote-store and remote-load requests with random router and memory back-pressure. The model compares every output in every cycle.

// File: rtl/rse_pkg.sv
package rse_pkg;
  localparam int NODE_W  = 10;
  localparam int MADDR_W = 22;
  localparam int DATA_W  = 32;
  localparam int MASK_W  = 4;
  localparam int OP_W    = 2;
  localparam int ADDR_W  = NODE_W + MADDR_W;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 2'b00,
    OP_STORE = 2'b01
  } rse_op_e;

  typedef struct packed {
    logic [NODE_W-1:0]  src_node;
    rse_op_e            op;
    logic [MASK_W-1:0]  mask;
    logic [DATA_W-1:0]  data;
    logic [NODE_W-1:0]  dst_node;
    logic [MADDR_W-1:0] maddr;
  } rse_flit_t;

  localparam int FLIT_W = $bits(rse_flit_t);
endpackage

// File: rtl/rse_classify.sv
module rse_classify
  import rse_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NODE_W-1:0]  my_node_i,
  output logic [NODE_W-1:0]  node_o,
  output logic [MADDR_W-1:0] maddr_o,
  output logic               is_local_o
);
  assign node_o     = addr_i[ADDR_W-1 -: NODE_W];
  assign maddr_o    = addr_i[MADDR_W-1:0];
  assign is_local_o = (node_o == my_node_i);
endmodule

// File: rtl/rse_flit_pack.sv
module rse_flit_pack
  import rse_pkg::*;
(
  input  logic [NODE_W-1:0]  src_node_i,
  input  logic [MASK_W-1:0]  mask_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [NODE_W-1:0]  dst_node_i,
  input  logic [MADDR_W-1:0] maddr_i,
  output logic [FLIT_W-1:0]  flit_o
);
  rse_flit_t f;
  always_comb begin
    f.src_node = src_node_i;
    f.op       = OP_STORE;
    f.mask     = mask_i;
    f.data     = data_i;
    f.dst_node = dst_node_i;
    f.maddr    = maddr_i;
  end
  assign flit_o = f;
endmodule

// File: rtl/rse_credit_ctr.sv
module rse_credit_ctr #(
  parameter int CREDIT_MAX = 8,
  localparam int CNT_W = $clog2(CREDIT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             give_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(CREDIT_MAX);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_q <= MAXV;
    else begin
      unique case ({take_i, give_i})
        2'b10:   cnt_q <= cnt_q - CNT_W'(1);
        2'b01:   cnt_q <= cnt_q + CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
  assign cnt_o = cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAXV);
  assert_bounded_return_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (give_i && !take_i) |-> (cnt_q != MAXV));
  assert_no_take_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (cnt_q != '0));
  assert_balance_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && give_i) |=> $stable(cnt_q));
  assert_take_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !give_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/rse_endpoint.sv
module rse_endpoint
  import rse_pkg::*;
#(
  parameter int CREDIT_MAX = 8,
  parameter int CRED_W     = 9,
  localparam int CNT_W     = $clog2(CREDIT_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NODE_W-1:0]  my_node_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_data_i,
  input  logic [MASK_W-1:0]  req_mask_i,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic               mem_write_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]  mem_data_o,
  output logic [MASK_W-1:0]  mem_mask_o,
  output logic               flit_valid_o,
  input  logic               flit_ready_i,
  output logic [FLIT_W-1:0]  flit_o,
  input  logic               cred_valid_i,
  input  logic [CRED_W-1:0]  cred_node_i,
  output logic [CNT_W-1:0]   credit_cnt_o,
  output logic               rload_err_o
);
  logic [NODE_W-1:0]  dst_node;
  logic [MADDR_W-1:0] maddr;
  logic               is_local, rem_store, rem_load, have_credit;
  logic               inject, credit_in;
  logic [CNT_W-1:0]   cnt;

  rse_classify u_classify (
    .addr_i     (req_addr_i),
    .my_node_i  (my_node_i),
    .node_o     (dst_node),
    .maddr_o    (maddr),
    .is_local_o (is_local)
  );

  rse_flit_pack u_pack (
    .src_node_i (my_node_i),
    .mask_i     (req_mask_i),
    .data_i     (req_data_i),
    .dst_node_i (dst_node),
    .maddr_i    (maddr),
    .flit_o     (flit_o)
  );

  rse_credit_ctr #(.CREDIT_MAX(CREDIT_MAX)) u_credit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (inject),
    .give_i (credit_in),
    .cnt_o  (cnt)
  );

  assign have_credit  = (cnt != '0);
  assign rem_store    = req_valid_i && !is_local && req_write_i;
  assign rem_load     = req_valid_i && !is_local && !req_write_i;
  assign flit_valid_o = rem_store && have_credit;
  assign inject       = flit_valid_o && flit_ready_i;
  assign credit_in    = cred_valid_i && (cred_node_i == my_node_i[CRED_W-1:0]);

  assign mem_valid_o  = req_valid_i && is_local;
  assign mem_write_o  = req_write_i;
  assign mem_addr_o   = maddr;
  assign mem_data_o   = req_data_i;
  assign mem_mask_o   = req_mask_i;

  always_comb begin
    if (is_local)         req_ready_o = mem_ready_i;
    else if (req_write_i) req_ready_o = have_credit && flit_ready_i;
    else                  req_ready_o = 1'b1;
  end

  assign rload_err_o  = rem_load;
  assign credit_cnt_o = cnt;

  assert_one_target_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_valid_o, flit_valid_o, rload_err_o}));
  assert_err_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rload_err_o |-> (req_ready_o && !flit_valid_o && !mem_valid_o));
  assert_flit_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_valid_o |-> (flit_o[FLIT_W-1 -: NODE_W] == my_node_i));
  assert_hold_flit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_valid_o && !flit_ready_i) |-> !req_ready_o);
endmodule

// File: tb/rse_endpoint_tb_top.sv
module rse_endpoint_tb_top;
  localparam int CMAX = 8;
  localparam logic [9:0] ME    = 10'h155;
  localparam logic [9:0] OTHER = 10'h0F3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid, req_write, mem_ready, flit_ready, cred_valid;
  logic [31:0] req_addr, req_data;
  logic [3:0]  req_mask;
  logic [8:0]  cred_node;
  logic        req_ready, mem_valid, mem_write, flit_valid, rload_err;
  logic [21:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  mem_mask;
  logic [79:0] flit;
  logic [3:0]  credit_cnt;

  rse_endpoint #(.CREDIT_MAX(CMAX), .CRED_W(9)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .my_node_i(ME),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_mask_i(req_mask),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_write_o(mem_write),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_mask_o(mem_mask),
    .flit_valid_o(flit_valid), .flit_ready_i(flit_ready), .flit_o(flit),
    .cred_valid_i(cred_valid), .cred_node_i(cred_node),
    .credit_cnt_o(credit_cnt), .rload_err_o(rload_err)
  );

  int n_vec = 0;
  int n_bad = 0;
  int m_cnt = CMAX;
  int owed  = 0;
  bit done  = 0;

  task automatic chk(string tag, logic [79:0] act, logic [79:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare against model, then advance model.
  task automatic step(bit v, bit w, logic [9:0] node, logic [21:0] ma,
                      logic [31:0] d, logic [3:0] m, bit mr, bit fr,
                      bit cv, logic [8:0] cn);
    bit loc, fv, inj, ret;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = {node, ma}; req_data = d;
    req_mask = m; mem_ready = mr; flit_ready = fr; cred_valid = cv; cred_node = cn;
    #1;
    loc = (node == ME);
    fv  = v && !loc && w && (m_cnt > 0);
    chk("R3 credit count", 80'(credit_cnt), 80'(m_cnt));
    chk("R1 mem valid", 80'(mem_valid), 80'(v && loc));
    if (v && loc) begin
      chk("R1 mem fields", {mem_write, mem_addr, mem_data, mem_mask},
          {1'b0, 21'h0, w, ma, d, m});
    end
    chk("R4 flit valid", 80'(flit_valid), 80'(fv));
    if (fv) chk("R2 flit layout", flit, {ME, 2'b01, m, d, node, ma});
    chk("R7 error pulse", 80'(rload_err), 80'(v && !loc && !w));
    if (loc)    chk("R1 ready", 80'(req_ready), 80'(mr));
    else if (w) chk("R8 ready", 80'(req_ready), 80'((m_cnt > 0) && fr));
    else        chk("R7 ready", 80'(req_ready), 80'(1'b1));
    inj = fv && fr;
    ret = cv && (cn == ME[8:0]);
    m_cnt = m_cnt - int'(inj) + int'(ret);
    owed  = owed + int'(inj) - int'(ret);
  endtask

  task automatic idle();
    step(0, 0, ME, 0, 0, 0, 0, 0, 0, 9'h0);
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_addr = 0; req_data = 0; req_mask = 0;
    mem_ready = 0; flit_ready = 0; cred_valid = 0; cred_node = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle();                                                   // R3 reset value
    // R1 local load and store, with and without memory ready
    step(1, 0, ME, 22'h12345, 32'hDEADBEEF, 4'hF, 1, 1, 0, 0);
    step(1, 1, ME, 22'h3FFFFF, 32'h01020304, 4'h3, 0, 1, 0, 0);
    // R2 remote store packing
    step(1, 1, OTHER, 22'h2AAAA, 32'hCAFEF00D, 4'h5, 0, 1, 0, 0);
    // R8 back-pressure: no credit consumed
    step(1, 1, OTHER, 22'h00001, 32'h11111111, 4'hF, 0, 0, 0, 0);
    step(1, 1, OTHER, 22'h00001, 32'h11111111, 4'hF, 0, 0, 0, 0);
    // R7 remote load
    step(1, 0, 10'h3FF, 22'h00042, 32'h0, 4'hF, 1, 1, 0, 0);
    // R9 back-to-back stores down to zero credits
    for (int i = 0; i < CMAX + 2; i++)
      step(1, 1, 10'(i + 1), 22'(i * 7), 32'(i * 32'h01010101), 4'(i), 0, 1, 0, 0);
    // R4 stall at zero
    step(1, 1, OTHER, 22'h1, 32'h2, 4'h1, 0, 1, 0, 0);
    // R6 credit for another node ignored
    step(0, 0, ME, 0, 0, 0, 0, 1, 1, 9'h0AA);
    idle();
    // R5 inject and return same cycle
    step(0, 0, ME, 0, 0, 0, 0, 1, 1, ME[8:0]);
    step(1, 1, OTHER, 22'h7, 32'h7, 4'h7, 0, 1, 1, ME[8:0]);
    idle();
    // return all credits: count back to maximum (R3)
    while (owed > 0) step(0, 0, ME, 0, 0, 0, 0, 0, 1, ME[8:0]);
    idle();
    chk("R3 back to max", 80'(m_cnt), 80'(CMAX));
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      bit cv;
      logic [8:0] cn;
      logic [9:0] nd;
      k  = $urandom_range(0, 9);
      nd = (k < 3) ? ME : 10'($urandom_range(0, 1023));
      cv = ($urandom_range(0, 3) == 0);
      cn = (owed > 0 && $urandom_range(0, 3) != 0) ? ME[8:0] : 9'h0AA;
      step($urandom_range(0, 4) != 0, k != 9, nd, 22'($urandom),
           $urandom, 4'($urandom), $urandom_range(0, 1) == 1,
           $urandom_range(0, 3) != 0, cv, cn);
    end
    while (owed > 0) step(0, 0, ME, 0, 0, 0, 0, 0, 1, ME[8:0]);
    idle();
    chk("R3 final max", 80'(credit_cnt), 80'(CMAX));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule